// File: doc/BRIEF.md
# SDRAM Command Monitor with Per-Bank State Tracking

This block sits on the command side of a single-data-rate SDRAM bus and watches the control pins at every rising clock edge. It turns chip select, the three strobes, the bank address and the A10 bit into one decoded command per cycle. It keeps a state for each bank and a chip-wide quiet window. Each command is judged against that state. A command that the memory would not accept raises a one-cycle illegal pulse together with a reason code. An illegal command leaves all tracked state as it was.

Timing limits are parameters given in clock cycles: row-to-column delay, precharge time, refresh cycle time and mode-set recovery. The burst length is sampled from an input whenever a read or write is accepted. The block is meant for protocol checking inside a memory subsystem, or as an observer next to a controller under test. It drives nothing onto the bus.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip select low, the pins {ras_n,cas_n,we_n} decode as 111 NOP, 011 ACT, 101 READ, 100 WRITE, 010 PRE, 001 REFA, 000 MRS and 110 burst terminate. With chip select high the command is NOP. cmd_o shows the command sampled at the previous edge, using the codes NOP 0, ACT 1, READ 2, READ-auto 3, WRITE 4, WRITE-auto 5, PRE 6, PRE-all 7, REFA 8, MRS 9, terminate 10.
- R2: A10 high turns READ into code 3, WRITE into code 5 and PRE into code 7 (all banks, bank address ignored).
- R3: bank_state_o holds 3 bits per bank, with bank n in bits [3n+2:3n]. The codes are idle 0, activating 1, active 2, reading 3, writing 4, reading-auto 5, writing-auto 6 and precharging 7. An ACT accepted at edge k moves an idle bank to activating. The bank reads active from edge k+T_RCD-1 on, and a command at edge k+T_RCD is judged against active.
- R4: READ, WRITE or terminate sent to an idle bank is illegal with reason 1. ACT sent to an active, reading or writing bank is illegal with reason 6.
- R5: A plain READ or WRITE accepted at edge k with burst length BL keeps the bank in reading or writing until edge k+BL-1, after which it reads active. A terminate ends the burst at once. A new READ or WRITE restarts the burst with the new length.
- R6: A READ or WRITE with auto-precharge runs its burst, then precharges, so that ACT is first accepted at edge k+BL+T_RP. Any terminate, READ, WRITE, ACT or PRE to that bank during the burst is illegal with reason 3.
- R7: PRE to an active, reading or writing bank moves it to precharging. The bank returns to idle T_RP cycles later. PRE to an idle or precharging bank is accepted and changes nothing. Any other command to an activating or precharging bank is illegal with reason 2.
- R8: PRE-all moves every active, reading or writing bank to precharging. It is illegal with reason 2 if any bank is activating, or reason 3 if any bank is in an auto-precharge burst.
- R9: REFA and MRS are illegal with reason 4 unless every bank is idle.
- R10: After a REFA or MRS accepted at edge k, every command other than NOP is illegal with reason 5 until edge k+T_RC (REFA) or k+T_RSC (MRS).
- R11: illegal_o is high for exactly the cycle after the offending edge, with reason_o nonzero. Reason 0 is reported when the command is legal. The chip-busy reason takes priority over the others. An illegal command changes no bank state.
- R12: Reset (rst_n low, asynchronous) returns all banks to idle, clears the busy window, and drives cmd_o, illegal_o and reason_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank qualifier |
| burst_len | input | 4 | Burst length in cycles, sampled on READ/WRITE (0 acts as 1) |
| cmd_o | output | 4 | Decoded command of the previous edge |
| bank_state_o | output | 12 | Per-bank state, 3 bits each |
| illegal_o | output | 1 | One-cycle illegal-command pulse |
| reason_o | output | 3 | Reason code for the pulse, 0 when legal |

## Verification
The embedded properties assume the pins carry known levels at every sampled edge and that reset is applied before the first command. They also assume that burst_len is stable around the edge that accepts a read or write. The stimulus drives every pin, including the bank address and A10, at the falling edge only. It always applies complete command codes, so no property sees an unknown or half-changed command. Burst lengths in the stimulus stay between 1 and 8, and reset is pulsed once at the start and once in the middle of traffic.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_RDA  = 4'd3,
    C_WR   = 4'd4,
    C_WRA  = 4'd5,
    C_PRE  = 4'd6,
    C_PREA = 4'd7,
    C_REF  = 4'd8,
    C_MRS  = 4'd9,
    C_TERM = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_OPENING = 3'd1,
    B_OPEN    = 3'd2,
    B_RD      = 3'd3,
    B_WR      = 3'd4,
    B_RDAP    = 3'd5,
    B_WRAP    = 3'd6,
    B_CLOSING = 3'd7
  } bank_e;

  typedef enum logic [2:0] {
    W_NONE      = 3'd0,
    W_IDLE_BANK = 3'd1,
    W_BANK_BUSY = 3'd2,
    W_AUTO_PRE  = 3'd3,
    W_NOT_IDLE  = 3'd4,
    W_CHIP_BUSY = 3'd5,
    W_ROW_OPEN  = 3'd6
  } why_e;

  function automatic logic is_banked(cmd_e c);
    return (c == C_ACT) || (c == C_RD) || (c == C_RDA) || (c == C_WR) ||
           (c == C_WRA) || (c == C_PRE) || (c == C_TERM);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = C_NOP;
        3'b011: cmd = C_ACT;
        3'b101: cmd = a10 ? C_RDA : C_RD;
        3'b100: cmd = a10 ? C_WRA : C_WR;
        3'b010: cmd = a10 ? C_PREA : C_PRE;
        3'b001: cmd = C_REF;
        3'b000: cmd = C_MRS;
        3'b110: cmd = C_TERM;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int BLW   = 4,
  parameter int CW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cmd_e           cmd,
  input  logic           sel,
  input  logic           prea,
  input  logic           go,
  input  logic [BLW-1:0] blen,
  output bank_e          state_o,
  output why_e           verdict_o
);
  localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);

  bank_e         st_q, st_d, eff;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] bl_ld;

  assign bl_ld = (blen == '0) ? '0 : CW'(blen) - CW'(1);

  // state as seen by the command at this edge
  always_comb begin
    eff = st_q;
    if (cnt_q == '0) begin
      unique case (st_q)
        B_OPENING:      eff = B_OPEN;
        B_CLOSING:      eff = B_IDLE;
        B_RD, B_WR:     eff = B_OPEN;
        B_RDAP, B_WRAP: eff = (T_RP <= 1) ? B_IDLE : B_CLOSING;
        default:        eff = st_q;
      endcase
    end
  end

  assign state_o = eff;

  always_comb begin
    verdict_o = W_NONE;
    if (sel) begin
      unique case (eff)
        B_IDLE:
          if (cmd == C_RD || cmd == C_RDA || cmd == C_WR || cmd == C_WRA || cmd == C_TERM)
            verdict_o = W_IDLE_BANK;
        B_OPENING:
          verdict_o = W_BANK_BUSY;
        B_CLOSING:
          if (cmd != C_PRE) verdict_o = W_BANK_BUSY;
        B_OPEN, B_RD, B_WR:
          if (cmd == C_ACT) verdict_o = W_ROW_OPEN;
        B_RDAP, B_WRAP:
          verdict_o = W_AUTO_PRE;
        default:
          verdict_o = W_NONE;
      endcase
    end
  end

  always_comb begin
    // natural progression of timed states
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q != B_IDLE && st_q != B_OPEN) begin
      if (cnt_q == '0) begin
        unique case (st_q)
          B_OPENING:      st_d = B_OPEN;
          B_CLOSING:      st_d = B_IDLE;
          B_RD, B_WR:     st_d = B_OPEN;
          B_RDAP, B_WRAP: begin st_d = B_CLOSING; cnt_d = RP_LD; end
          default:        st_d = st_q;
        endcase
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
    // accepted commands override
    if (go && sel) begin
      unique case (cmd)
        C_ACT: begin st_d = B_OPENING; cnt_d = RCD_LD; end
        C_RD:  begin st_d = B_RD;   cnt_d = bl_ld; end
        C_RDA: begin st_d = B_RDAP; cnt_d = bl_ld; end
        C_WR:  begin st_d = B_WR;   cnt_d = bl_ld; end
        C_WRA: begin st_d = B_WRAP; cnt_d = bl_ld; end
        C_PRE:
          if (eff == B_OPEN || eff == B_RD || eff == B_WR) begin
            st_d = B_CLOSING; cnt_d = RP_LD;
          end
        C_TERM:
          if (eff == B_RD || eff == B_WR) begin
            st_d = B_OPEN; cnt_d = '0;
          end
        default: ;
      endcase
    end else if (go && prea) begin
      if (eff == B_OPEN || eff == B_RD || eff == B_WR) begin
        st_d = B_CLOSING; cnt_d = RP_LD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: a bank only starts activating from idle
  assert_act_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == B_OPENING && $past(st_q) != B_OPENING) |-> $past(eff) == B_IDLE);

  // R6: an auto-precharge burst can only leave towards precharging
  assert_auto_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) == B_RDAP || $past(st_q) == B_WRAP) && st_q != $past(st_q))
      |-> st_q == B_CLOSING);

  // R11: a rejected command leaves the bank on its natural course
  assert_reject_no_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && verdict_o != W_NONE && eff == B_IDLE) |=> st_q == B_IDLE);

endmodule

// File: rtl/sdram_chip_timer.sv
module sdram_chip_timer #(
  parameter int T_RC  = 8,
  parameter int T_RSC = 2,
  parameter int CW    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ref,
  input  logic start_mrs,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start_ref)  cnt_q <= CW'(T_RC - 1);
    else if (start_mrs)  cnt_q <= CW'(T_RSC - 1);
    else if (busy_o)     cnt_q <= cnt_q - CW'(1);
  end

  // R10: no new refresh or mode set is accepted inside the quiet window
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(start_ref || start_mrs));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int T_RCD     = 3,
  parameter  int T_RP      = 3,
  parameter  int T_RC      = 8,
  parameter  int T_RSC     = 2,
  parameter  int BLW       = 4,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  input  logic [BLW-1:0]         burst_len,
  output logic [3:0]             cmd_o,
  output logic [NUM_BANKS*3-1:0] bank_state_o,
  output logic                   illegal_o,
  output logic [2:0]             reason_o
);
  localparam int BMAX  = (1 << BLW);
  localparam int TMAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TMAXB = (TMAX1 > BMAX) ? TMAX1 : BMAX;
  localparam int BCW   = $clog2(TMAXB + 1);
  localparam int TMAXC = (T_RC > T_RSC) ? T_RC : T_RSC;
  localparam int CCW   = $clog2(TMAXC + 1);

  cmd_e  cmd;
  why_e  why;
  logic  go, busy, prea;
  bank_e eff   [NUM_BANKS];
  why_e  vrd   [NUM_BANKS];
  logic  any_busy, any_auto, all_idle;
  why_e  bank_why;

  cmd_e  cmd_q;
  why_e  why_q;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10  (a10),  .cmd  (cmd)
  );

  assign prea = (cmd == C_PREA);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_b;
    assign sel_b = is_banked(cmd) && (ba == BA_W'(b));
    sdram_bank_track #(.T_RCD(T_RCD), .T_RP(T_RP), .BLW(BLW), .CW(BCW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .sel      (sel_b),
      .prea     (prea),
      .go       (go),
      .blen     (burst_len),
      .state_o  (eff[b]),
      .verdict_o(vrd[b])
    );
    assign bank_state_o[3*b +: 3] = eff[b];
  end

  always_comb begin
    any_busy = 1'b0;
    any_auto = 1'b0;
    all_idle = 1'b1;
    bank_why = W_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (eff[b] == B_OPENING) any_busy = 1'b1;
      if (eff[b] == B_RDAP || eff[b] == B_WRAP) any_auto = 1'b1;
      if (eff[b] != B_IDLE) all_idle = 1'b0;
      if (vrd[b] != W_NONE) bank_why = vrd[b];
    end
  end

  always_comb begin
    why = W_NONE;
    if (cmd == C_NOP)                       why = W_NONE;
    else if (busy)                          why = W_CHIP_BUSY;
    else if (cmd == C_REF || cmd == C_MRS)  why = all_idle ? W_NONE : W_NOT_IDLE;
    else if (prea) begin
      if (any_busy)      why = W_BANK_BUSY;
      else if (any_auto) why = W_AUTO_PRE;
    end else                                why = bank_why;
  end

  assign go = (why == W_NONE);

  sdram_chip_timer #(.T_RC(T_RC), .T_RSC(T_RSC), .CW(CCW)) u_chip (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ref(go && cmd == C_REF),
    .start_mrs(go && cmd == C_MRS),
    .busy_o   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= C_NOP;
      why_q <= W_NONE;
    end else begin
      cmd_q <= cmd;
      why_q <= why;
    end
  end

  assign cmd_o     = cmd_q;
  assign reason_o  = why_q;
  assign illegal_o = (why_q != W_NONE);

  // R11: a pulse is only ever raised for a real command
  assert_pulse_real_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> cmd_o != C_NOP);

  // R10: while the quiet window runs, no bank has left idle
  assert_quiet_all_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> all_idle);

  // R9: an accepted refresh or mode set finds every bank idle
  assert_ref_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == C_REF || cmd_o == C_MRS) && !illegal_o) |-> $past(all_idle));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0]  ba;
  logic [3:0]  burst_len;
  logic [3:0]  cmd_o;
  logic [11:0] bank_state_o;
  logic        illegal_o;
  logic [2:0]  reason_o;

  int n_vec  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .burst_len(burst_len),
    .cmd_o(cmd_o), .bank_state_o(bank_state_o), .illegal_o(illegal_o),
    .reason_o(reason_o)
  );

  typedef struct packed {
    logic [3:0]  pins;   // cs_n, ras_n, cas_n, we_n
    logic [1:0]  ba;
    logic        a10;
    logic [3:0]  bl;
    logic [3:0]  ecmd;
    logic        eill;
    logic [2:0]  ersn;
    logic [11:0] est;    // octal digit per bank, bank3..bank0
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R1 NOP
    '{4'b1000, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R1 deselect
    '{4'b0101, 2'd0, 1'b0, 4'd1, 4'd2,  1'b1, 3'd1, 12'o0000}, // R4 read idle
    '{4'b0110, 2'd1, 1'b0, 4'd1, 4'd10, 1'b1, 3'd1, 12'o0000}, // R4 term idle
    '{4'b0011, 2'd0, 1'b0, 4'd1, 4'd1,  1'b0, 3'd0, 12'o0001}, // R3 ACT
    '{4'b0101, 2'd0, 1'b0, 4'd1, 4'd2,  1'b1, 3'd2, 12'o0001}, // R3 read activating
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0002}, // R3 active
    '{4'b0011, 2'd0, 1'b0, 4'd1, 4'd1,  1'b1, 3'd6, 12'o0002}, // R4 ACT open
    '{4'b0011, 2'd1, 1'b0, 4'd1, 4'd1,  1'b0, 3'd0, 12'o0012}, // R3 ACT bank1
    '{4'b0101, 2'd0, 1'b0, 4'd2, 4'd2,  1'b0, 3'd0, 12'o0013}, // R5 read BL2
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0022}, // R5 burst over
    '{4'b0100, 2'd0, 1'b1, 4'd2, 4'd5,  1'b0, 3'd0, 12'o0026}, // R2 write auto
    '{4'b0101, 2'd0, 1'b0, 4'd1, 4'd2,  1'b1, 3'd3, 12'o0027}, // R6 read during auto
    '{4'b0011, 2'd0, 1'b0, 4'd1, 4'd1,  1'b1, 3'd2, 12'o0027}, // R6 ACT precharging
    '{4'b0101, 2'd1, 1'b0, 4'd4, 4'd2,  1'b0, 3'd0, 12'o0037}, // R5 read BL4
    '{4'b0110, 2'd1, 1'b0, 4'd1, 4'd10, 1'b0, 3'd0, 12'o0020}, // R5 term, R6 idle
    '{4'b0100, 2'd1, 1'b0, 4'd8, 4'd4,  1'b0, 3'd0, 12'o0040}, // R5 write BL8
    '{4'b0101, 2'd1, 1'b0, 4'd2, 4'd2,  1'b0, 3'd0, 12'o0030}, // R5 restart read
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0020}, // R5 burst over
    '{4'b0010, 2'd0, 1'b0, 4'd1, 4'd6,  1'b0, 3'd0, 12'o0020}, // R7 PRE idle
    '{4'b0001, 2'd0, 1'b0, 4'd1, 4'd8,  1'b1, 3'd4, 12'o0020}, // R9 REFA open
    '{4'b0011, 2'd2, 1'b0, 4'd1, 4'd1,  1'b0, 3'd0, 12'o0120}, // R3 ACT bank2
    '{4'b0010, 2'd3, 1'b1, 4'd1, 4'd7,  1'b1, 3'd2, 12'o0120}, // R8 PREA activating
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0220}, // R11 pulse one cycle
    '{4'b0010, 2'd0, 1'b1, 4'd1, 4'd7,  1'b0, 3'd0, 12'o0770}, // R8 PREA
    '{4'b0010, 2'd1, 1'b0, 4'd1, 4'd6,  1'b0, 3'd0, 12'o0770}, // R7 PRE precharging
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R7 idle after tRP
    '{4'b0001, 2'd0, 1'b0, 4'd1, 4'd8,  1'b0, 3'd0, 12'o0000}, // R9 REFA ok
    '{4'b0011, 2'd0, 1'b0, 4'd1, 4'd1,  1'b1, 3'd5, 12'o0000}, // R10 ACT busy
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R10 NOP ok
    '{4'b1000, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R1
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R10
    '{4'b1000, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R1
    '{4'b0111, 2'd0, 1'b0, 4'd1, 4'd0,  1'b0, 3'd0, 12'o0000}, // R10
    '{4'b0000, 2'd0, 1'b0, 4'd1, 4'd9,  1'b1, 3'd5, 12'o0000}, // R10 last busy edge
    '{4'b0000, 2'd0, 1'b0, 4'd1, 4'd9,  1'b0, 3'd0, 12'o0000}, // R10 MRS at k+T_RC
    '{4'b0011, 2'd3, 1'b0, 4'd1, 4'd1,  1'b1, 3'd5, 12'o0000}, // R10 inside tRSC
    '{4'b0011, 2'd3, 1'b0, 4'd1, 4'd1,  1'b0, 3'd0, 12'o1000}, // R3 ACT bank3
    '{4'b0000, 2'd0, 1'b0, 4'd1, 4'd9,  1'b1, 3'd4, 12'o1000}  // R9 MRS open
  };

  task automatic drive(input logic [3:0] p, input logic [1:0] b, input logic a, input logic [3:0] l);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b; a10 = a; burst_len = l;
  endtask

  task automatic check(input string req, input logic [3:0] ec, input logic ei,
                       input logic [2:0] er, input logic [11:0] es);
    n_vec++;
    if (cmd_o !== ec || illegal_o !== ei || reason_o !== er || bank_state_o !== es) begin
      n_fail++;
      $display("FAIL %s: cmd/ill/rsn/st = %0d/%0b/%0d/%o expected %0d/%0b/%0d/%o",
               req, cmd_o, illegal_o, reason_o, bank_state_o, ec, ei, er, es);
    end
  endtask

  initial begin
    drive(4'b0111, 2'd0, 1'b0, 4'd1);
    repeat (3) @(negedge clk);
    check("R12 reset", 4'd0, 1'b0, 3'd0, 12'o0000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].pins, VEC[i].ba, VEC[i].a10, VEC[i].bl);
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i].ecmd, VEC[i].eill, VEC[i].ersn, VEC[i].est);
    end
    // R3: ACT bank0 while bank3 finishes activating
    drive(4'b0011, 2'd0, 1'b0, 4'd1);
    @(negedge clk);
    check("R3 act bank0", 4'd1, 1'b0, 3'd0, 12'o2001);
    // R12: reset in the middle of traffic
    drive(4'b0111, 2'd0, 1'b0, 4'd1);
    #1 rst_n = 1'b0;
    #1 check("R12 mid reset", 4'd0, 1'b0, 3'd0, 12'o0000);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b0101, 2'd0, 1'b0, 4'd1);
    @(negedge clk);
    check("R12 idle after reset", 4'd2, 1'b1, 3'd1, 12'o0000);
    drive(4'b0111, 2'd0, 1'b0, 4'd1);
    @(negedge clk);
    check("R11 pulse cleared", 4'd0, 1'b0, 3'd0, 12'o0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule